// File: doc/BRIEF.md
# Exception and Trap Entry Controller

This block performs the register bookkeeping a small 32-bit processor needs when an instruction takes an address fault, executes a trap, or returns from a handler. The pipeline reports the event with a one-cycle strobe and the address of the instruction involved. In the following cycle the block presents a redirect target with a one-cycle valid pulse, and its saved-state registers hold their new values.

It holds a status byte, a backup copy of that byte, a two-deep chain of saved program counters and a programmable vector base. Entry into a handler saves the status byte and then clears every status bit except stack mode. An address fault moves the existing saved PC one level down the chain before it records the faulting address. A trap is sent to the vector base plus a fixed offset plus four times its number. One reserved trap number is treated as a no-op that continues at the next word. A return restores the status byte, jumps to the saved PC and pulls the second-level PC back up.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is held, and after it is released, status, backup status, both saved PCs, vector base, redirect target and redirect valid all read zero.
- R2: On an address fault, the second-level saved PC takes the old first-level saved PC, and the first-level saved PC takes the current instruction address, both visible one cycle after the strobe.
- R3: On an address fault or a vectored trap, the backup status takes the whole old status byte, and the status byte keeps only bit 7 (stack mode) with all other bits cleared.
- R4: An address fault redirects to the parameter `ADDR_EXC_VEC`.
- R5: A vectored trap with 4-bit number n redirects to vector base + 0x40 + 4*n, with modulo 2^32 wrap. The first-level saved PC takes (address & ~3) + 4 and the second-level saved PC is unchanged.
- R6: Trap number 12 redirects to (address & ~3) + 4 and leaves status, backup status and both saved PCs unchanged.
- R7: When strobes coincide, an address fault wins over a trap, and a trap wins over a return.
- R8: A return sets status from backup status, redirects to the first-level saved PC, and moves the second-level saved PC into the first level. Backup status and the second-level PC keep their values.
- R9: Redirect valid is high in exactly the cycle after an event, and low otherwise. The redirect target holds its value in cycles without an event.
- R10: A vector-base write takes effect in the next cycle. A trap in the same cycle still uses the old base.
- R11: A status write loads the status byte only in a cycle with no event. In a cycle with a fault, trap or return it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | Address of the instruction raising the event |
| addr_fault | input | 1 | Address-fault strobe |
| trap_go | input | 1 | Trap strobe |
| trap_num | input | 4 | Trap number |
| rte_go | input | 1 | Return-from-exception strobe |
| vbase_we | input | 1 | Vector-base write enable |
| vbase_wdata | input | 32 | Vector-base write data |
| psw_we | input | 1 | Status write enable |
| psw_wdata | input | 8 | Status write data |
| redirect_pc | output | 32 | Redirect target |
| redirect_vld | output | 1 | One-cycle redirect pulse |
| psw | output | 8 | Status byte |
| bpsw | output | 8 | Backup status byte |
| bpc | output | 32 | First-level saved PC |
| bbpc | output | 32 | Second-level saved PC |
| vbase | output | 32 | Vector base |

## Verification
The bench builds the block with `ADDR_EXC_VEC` overridden to 0xFFFF1000, so that a fault vector cannot be mistaken for a reset-zero target or a trap target. All other parameters keep their defaults. With the 4-bit trap field every trap number can be reached, including 15 (offset 0x7C) and the reserved number 12. A vector base near the top of the address space brings the 32-bit wrap of the trap target within reach. Random sequences of faults and returns work the two-deep PC chain in both directions.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Event selected for the current cycle after priority resolution
    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_FAULT = 3'd1,
        EV_TRAP  = 3'd2,
        EV_FLUSH = 3'd3,
        EV_RTE   = 3'd4
    } exc_ev_e;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int TNUM_W    = 4,
    parameter int FLUSH_NUM = 12
) (
    input  logic              fault_i,
    input  logic              trap_i,
    input  logic [TNUM_W-1:0] trap_num_i,
    input  logic              rte_i,
    output exc_ev_e           ev_o
);
    localparam logic [TNUM_W-1:0] FLUSH_CODE = TNUM_W'(FLUSH_NUM);

    // Fault outranks trap; trap outranks return (R7)
    always_comb begin
        ev_o = EV_NONE;
        if (fault_i) begin
            ev_o = EV_FAULT;
        end else if (trap_i) begin
            ev_o = (trap_num_i == FLUSH_CODE) ? EV_FLUSH : EV_TRAP;
        end else if (rte_i) begin
            ev_o = EV_RTE;
        end
    end
endmodule

// File: rtl/exc_status.sv
module exc_status
    import exc_pkg::*;
#(
    parameter int PSW_W  = 8,
    parameter int SM_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  exc_ev_e          ev_i,
    input  logic             psw_we_i,
    input  logic [PSW_W-1:0] psw_wdata_i,
    output logic [PSW_W-1:0] psw_o,
    output logic [PSW_W-1:0] bpsw_o
);
    localparam logic [PSW_W-1:0] KEEP_MASK = PSW_W'(1) << SM_BIT;

    typedef struct packed {
        logic [PSW_W-1:0] psw;
        logic [PSW_W-1:0] bpsw;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (ev_i)
            EV_FAULT, EV_TRAP: begin
                st_d.bpsw = st_q.psw;
                st_d.psw  = st_q.psw & KEEP_MASK;
            end
            EV_RTE: begin
                st_d.psw = st_q.bpsw;
            end
            EV_FLUSH: begin
            end
            default: begin
                if (psw_we_i) begin
                    st_d.psw = psw_wdata_i;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign psw_o  = st_q.psw;
    assign bpsw_o = st_q.bpsw;

    // R3: entry saves the status and keeps only the stack-mode bit
    a_r3_entry_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_FAULT || ev_i == EV_TRAP) |=>
            (bpsw_o == $past(psw_o)) && (psw_o == ($past(psw_o) & KEEP_MASK)));

    // R8: return restores status from the backup
    a_r8_restore_psw: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_RTE) |=> (psw_o == $past(bpsw_o)) && $stable(bpsw_o));

    // R11: a status write lands only in a quiet cycle
    a_r11_psw_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_NONE && psw_we_i) |=> (psw_o == $past(psw_wdata_i)));

    // R6: the flush trap leaves both status bytes alone
    a_r6_flush_psw: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_FLUSH) |=> $stable(psw_o) && $stable(bpsw_o));
endmodule

// File: rtl/exc_pcchain.sv
module exc_pcchain
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  exc_ev_e         ev_i,
    input  logic [XLEN-1:0] cur_pc_i,
    output logic [XLEN-1:0] bpc_o,
    output logic [XLEN-1:0] bbpc_o
);
    localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);
    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0] bpc;
        logic [XLEN-1:0] bbpc;
    } chain_t;

    chain_t ch_d, ch_q;
    logic [XLEN-1:0] ret_addr;

    assign ret_addr = (cur_pc_i & WORD_MASK) + WORD_STEP;

    always_comb begin
        ch_d = ch_q;
        unique case (ev_i)
            EV_FAULT: begin
                // push: old first level moves down before the overwrite
                ch_d.bbpc = ch_q.bpc;
                ch_d.bpc  = cur_pc_i;
            end
            EV_TRAP: begin
                ch_d.bpc = ret_addr;
            end
            EV_RTE: begin
                // pop: second level moves back up
                ch_d.bpc = ch_q.bbpc;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign bpc_o  = ch_q.bpc;
    assign bbpc_o = ch_q.bbpc;

    // R2: fault pushes the chain
    a_r2_fault_push: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_FAULT) |=> (bbpc_o == $past(bpc_o)) && (bpc_o == $past(cur_pc_i)));

    // R8: return pops the chain
    a_r8_rte_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_RTE) |=> (bpc_o == $past(bbpc_o)) && $stable(bbpc_o));

    // R5: a vectored trap leaves the second level alone
    a_r5_trap_keep_bbpc: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_TRAP) |=> $stable(bbpc_o));

    // R6: the flush trap leaves the chain alone
    a_r6_flush_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_FLUSH) |=> $stable(bpc_o) && $stable(bbpc_o));
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              TNUM_W       = 4,
    parameter logic [XLEN-1:0] TRAP_OFS     = 32'h0000_0040,
    parameter logic [XLEN-1:0] ADDR_EXC_VEC = 32'h0000_0030
) (
    input  logic              clk,
    input  logic              rst_n,
    input  exc_ev_e           ev_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic [TNUM_W-1:0] trap_num_i,
    input  logic [XLEN-1:0]   bpc_i,
    input  logic              vbase_we_i,
    input  logic [XLEN-1:0]   vbase_wdata_i,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic              redirect_vld_o,
    output logic [XLEN-1:0]   vbase_o
);
    localparam int              PAD_W     = XLEN - TNUM_W - 2;
    localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);
    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0] rpc;
        logic            vld;
        logic [XLEN-1:0] vbase;
    } tgt_t;

    tgt_t tg_d, tg_q;
    logic [XLEN-1:0] trap_vec;
    logic [XLEN-1:0] next_word;

    assign trap_vec  = tg_q.vbase + TRAP_OFS + {{PAD_W{1'b0}}, trap_num_i, 2'b00};
    assign next_word = (cur_pc_i & WORD_MASK) + WORD_STEP;

    always_comb begin
        tg_d     = tg_q;
        tg_d.vld = 1'b1;
        unique case (ev_i)
            EV_FAULT: tg_d.rpc = ADDR_EXC_VEC;
            EV_TRAP:  tg_d.rpc = trap_vec;
            EV_FLUSH: tg_d.rpc = next_word;
            EV_RTE:   tg_d.rpc = bpc_i;
            default:  tg_d.vld = 1'b0;
        endcase
        if (vbase_we_i) begin
            tg_d.vbase = vbase_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tg_q <= '0;
        end else begin
            tg_q <= tg_d;
        end
    end

    assign redirect_pc_o  = tg_q.rpc;
    assign redirect_vld_o = tg_q.vld;
    assign vbase_o        = tg_q.vbase;

    // R4: fault goes to the fixed vector
    a_r4_fault_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_FAULT) |=> redirect_vld_o && (redirect_pc_o == ADDR_EXC_VEC));

    // R8: return jumps to the saved PC
    a_r8_rte_target: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_RTE) |=> redirect_vld_o && (redirect_pc_o == $past(bpc_i)));

    // R9: a quiet cycle gives no pulse and holds the target
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_NONE) |=> !redirect_vld_o && $stable(redirect_pc_o));

    // R10: base write is visible next cycle
    a_r10_vbase_write: assert property (@(posedge clk) disable iff (!rst_n)
        vbase_we_i |=> (vbase_o == $past(vbase_wdata_i)));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              TNUM_W       = 4,
    parameter int              PSW_W        = 8,
    parameter int              SM_BIT       = 7,
    parameter int              FLUSH_NUM    = 12,
    parameter logic [XLEN-1:0] TRAP_OFS     = 32'h0000_0040,
    parameter logic [XLEN-1:0] ADDR_EXC_VEC = 32'h0000_0030
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              addr_fault,
    input  logic              trap_go,
    input  logic [TNUM_W-1:0] trap_num,
    input  logic              rte_go,
    input  logic              vbase_we,
    input  logic [XLEN-1:0]   vbase_wdata,
    input  logic              psw_we,
    input  logic [PSW_W-1:0]  psw_wdata,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              redirect_vld,
    output logic [PSW_W-1:0]  psw,
    output logic [PSW_W-1:0]  bpsw,
    output logic [XLEN-1:0]   bpc,
    output logic [XLEN-1:0]   bbpc,
    output logic [XLEN-1:0]   vbase
);
    exc_ev_e ev;

    exc_arbiter #(
        .TNUM_W   (TNUM_W),
        .FLUSH_NUM(FLUSH_NUM)
    ) u_arb (
        .fault_i   (addr_fault),
        .trap_i    (trap_go),
        .trap_num_i(trap_num),
        .rte_i     (rte_go),
        .ev_o      (ev)
    );

    exc_status #(
        .PSW_W (PSW_W),
        .SM_BIT(SM_BIT)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .psw_we_i   (psw_we),
        .psw_wdata_i(psw_wdata),
        .psw_o      (psw),
        .bpsw_o     (bpsw)
    );

    exc_pcchain #(
        .XLEN(XLEN)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .cur_pc_i(cur_pc),
        .bpc_o   (bpc),
        .bbpc_o  (bbpc)
    );

    exc_target #(
        .XLEN        (XLEN),
        .TNUM_W      (TNUM_W),
        .TRAP_OFS    (TRAP_OFS),
        .ADDR_EXC_VEC(ADDR_EXC_VEC)
    ) u_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_i          (ev),
        .cur_pc_i      (cur_pc),
        .trap_num_i    (trap_num),
        .bpc_i         (bpc),
        .vbase_we_i    (vbase_we),
        .vbase_wdata_i (vbase_wdata),
        .redirect_pc_o (redirect_pc),
        .redirect_vld_o(redirect_vld),
        .vbase_o       (vbase)
    );

    // R7: a fault strobe always wins, whatever else is raised
    a_r7_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_fault && trap_go) |=> redirect_vld && (redirect_pc == ADDR_EXC_VEC));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
    localparam logic [31:0] VEC = 32'hFFFF_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        addr_fault = 1'b0, trap_go = 1'b0, rte_go = 1'b0;
    logic [3:0]  trap_num = '0;
    logic        vbase_we = 1'b0, psw_we = 1'b0;
    logic [31:0] vbase_wdata = '0;
    logic [7:0]  psw_wdata = '0;
    logic [31:0] redirect_pc, bpc, bbpc, vbase;
    logic        redirect_vld;
    logic [7:0]  psw, bpsw;

    exc_entry_ctrl #(.ADDR_EXC_VEC(VEC)) dut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .addr_fault(addr_fault),
        .trap_go(trap_go), .trap_num(trap_num), .rte_go(rte_go),
        .vbase_we(vbase_we), .vbase_wdata(vbase_wdata), .psw_we(psw_we),
        .psw_wdata(psw_wdata), .redirect_pc(redirect_pc), .redirect_vld(redirect_vld),
        .psw(psw), .bpsw(bpsw), .bpc(bpc), .bbpc(bbpc), .vbase(vbase)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0]  m_psw = '0, m_bpsw = '0;
    logic [31:0] m_bpc = '0, m_bbpc = '0, m_vb = '0, m_rpc = '0;
    logic        m_vld = 1'b0;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] next_word(logic [31:0] a);
        return (a & 32'hFFFF_FFFC) + 32'd4;
    endfunction

    task automatic check_all(string tag);
        chk(tag, {31'd0, redirect_vld}, {31'd0, m_vld}, "redirect_vld");
        chk(tag, redirect_pc, m_rpc, "redirect_pc");
        chk(tag, {24'd0, psw}, {24'd0, m_psw}, "psw");
        chk(tag, {24'd0, bpsw}, {24'd0, m_bpsw}, "bpsw");
        chk(tag, bpc, m_bpc, "bpc");
        chk(tag, bbpc, m_bbpc, "bbpc");
        chk(tag, vbase, m_vb, "vbase");
    endtask

    // one cycle: drive, update reference, check after the edge
    task automatic step(string tag, logic f, logic t, logic [3:0] n, logic r,
                        logic [31:0] pc, logic vwe, logic [31:0] vwd,
                        logic pwe, logic [7:0] pwd);
        logic [7:0]  o_psw, o_bpsw;
        logic [31:0] o_bpc, o_bbpc, o_vb;
        @(negedge clk);
        addr_fault = f; trap_go = t; trap_num = n; rte_go = r; cur_pc = pc;
        vbase_we = vwe; vbase_wdata = vwd; psw_we = pwe; psw_wdata = pwd;
        o_psw = m_psw; o_bpsw = m_bpsw; o_bpc = m_bpc; o_bbpc = m_bbpc; o_vb = m_vb;
        m_vld = 1'b1;
        if (f) begin
            m_bbpc = o_bpc; m_bpc = pc; m_bpsw = o_psw; m_psw = o_psw & 8'h80; m_rpc = VEC;
        end else if (t && n == 4'd12) begin
            m_rpc = next_word(pc);
        end else if (t) begin
            m_bpsw = o_psw; m_psw = o_psw & 8'h80; m_bpc = next_word(pc);
            m_rpc = o_vb + 32'h40 + {26'd0, n, 2'b00};
        end else if (r) begin
            m_psw = o_bpsw; m_rpc = o_bpc; m_bpc = o_bbpc;
        end else begin
            m_vld = 1'b0;
            if (pwe) m_psw = pwd;
        end
        if (vwe) m_vb = vwd;
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 4'd0, 0, 32'd0, 0, 32'd0, 0, 8'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");

        // R11: status write in a quiet cycle
        step("R11", 0, 0, 4'd0, 0, 32'd0, 0, 32'd0, 1, 8'hFF);
        // R3/R4/R2: fault masks status, pushes chain, jumps to fixed vector
        step("R3", 1, 0, 4'd0, 0, 32'h0000_2002, 0, 32'd0, 0, 8'd0);
        step("R2", 1, 0, 4'd0, 0, 32'h0000_3010, 0, 32'd0, 0, 8'd0);
        idle("R9");
        // R10: base write plus trap in same cycle uses the old base
        step("R10", 0, 1, 4'd3, 0, 32'h0000_4000, 1, 32'hFFFF_FFF0, 0, 8'd0);
        // R5: trap 15 with base near the top wraps
        step("R5", 0, 1, 4'd15, 0, 32'h0000_5003, 0, 32'd0, 0, 8'd0);
        // R6: reserved trap number
        step("R11", 0, 0, 4'd0, 0, 32'd0, 0, 32'd0, 1, 8'h5A);
        step("R6", 0, 1, 4'd12, 0, 32'h0000_6006, 0, 32'd0, 0, 8'd0);
        // R11: status write alongside an event is dropped
        step("R11", 0, 1, 4'd1, 0, 32'h0000_7000, 0, 32'd0, 1, 8'h33);
        // R7: fault beats trap and return; trap beats return
        step("R7", 1, 1, 4'd2, 1, 32'h0000_8000, 0, 32'd0, 0, 8'd0);
        step("R7", 0, 1, 4'd4, 1, 32'h0000_9000, 0, 32'd0, 0, 8'd0);
        // R8: returns unwind the chain
        step("R8", 0, 0, 4'd0, 1, 32'd0, 0, 32'd0, 0, 8'd0);
        step("R8", 0, 0, 4'd0, 1, 32'd0, 0, 32'd0, 0, 8'd0);
        idle("R9");
        idle("R9");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int sel = $urandom_range(0, 9);
            logic f = (sel == 0 || sel == 1);
            logic t = (sel >= 2 && sel <= 4) || ($urandom_range(0, 7) == 0);
            logic r = (sel == 5 || sel == 6) || ($urandom_range(0, 7) == 0);
            logic [3:0] n = ($urandom_range(0, 3) == 0) ? 4'd12 : 4'($urandom_range(0, 15));
            string tag;
            if (f) tag = "R2";
            else if (t && n == 4'd12) tag = "R6";
            else if (t) tag = "R5";
            else if (r) tag = "R8";
            else tag = "R9";
            step(tag, f, t, n, r, $urandom(), ($urandom_range(0, 5) == 0), $urandom(),
                 ($urandom_range(0, 2) == 0), 8'($urandom_range(0, 255)));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule